// File: doc/BRIEF.md
# Indirect-Addressed Byte Memory Window with Lockable Regions

This block gives a host access to a byte-wide memory through a window of four byte offsets. The host writes a 16-bit pointer in two halves, low byte and high byte, through two offsets. It then moves one data byte at a time through the data offset. Every data write leaves the pointer at zero. Reads do not move the pointer, so a location can be polled.

The storage is an internal register array of `MEM_BYTES` bytes. Any pointer value at or past that size reads as all ones and drops writes, with no wrap-around. Two 16-byte regions can each be locked by its own toggle input. A locked region drops writes and reads as all ones. The byte at `EXT_BASE` is a constant, read-only flags byte when `EXT_FULL` is 1. With `EXT_FULL` at 0 it is ordinary memory.

Host requests use a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted read, whatever its offset, gives one response beat on a second valid/ready channel. `rsp_valid` rises one cycle after acceptance. It stays high with `rsp_data` frozen until `rsp_ready` is high on a clock edge. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so at most one response is ever outstanding.

Top module: `nvram_window_port`

## Requirements
- R1: An accepted write at offset 0 loads pointer bits 7:0 and one at offset 1 loads pointer bits 15:8. An accepted write at offset 3 stores `req_wdata` at the pointer, and a read at offset 3 returns the byte at the pointer.
- R2: After an accepted write at offset 3 the pointer is 0x0000. This holds whether or not the byte was stored.
- R3: A read at offset 0, 1 or 2 returns 0xFF. No read changes the pointer.
- R4: An accepted write at offset 2 changes neither the pointer nor the memory.
- R5: While lock bit 0 is set, pointer values 0x0020 to 0x002F read as 0xFF and writes to them are dropped. Neighbouring addresses are unaffected, and clearing the bit restores the old contents.
- R6: While lock bit 1 is set, pointer values 0x0030 to 0x003F read as 0xFF and writes to them are dropped. Neighbouring addresses are unaffected.
- R7: A high `lock_tgl[i]` on a clock edge inverts lock bit i. Reset clears both lock bits.
- R8: A pointer value at or above `MEM_BYTES` reads as 0xFF. Writes to such a value are dropped and do not alias onto lower addresses.
- R9: With `EXT_FULL`=1, address `EXT_BASE` reads `FLAGS_VALUE` and ignores writes. With `EXT_FULL`=0 it behaves as plain memory.
- R10: `rsp_valid` rises one cycle after a read is accepted. While `rsp_ready` is low it stays high with `rsp_data` unchanged, and `req_ready` is low. After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| lock_tgl | input | 2 | Per-bit lock toggle enables |

## Verification
The bench builds two copies with `MEM_BYTES`=128 and `EXT_BASE`=0x70. One copy has `EXT_FULL`=1 and `FLAGS_VALUE`=0xA5, and the other has `EXT_FULL`=0. Both share one stimulus stream. At this size, every in-range address and the first sixteen addresses past the limit can be written and then read back. A few far addresses are covered too. Aliasing, the flags byte in both variants, and every cell on both sides of each lock region are all compared against a behavioural model kept in the bench.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  localparam logic [1:0] OFF_PTR_LO = 2'd0;
  localparam logic [1:0] OFF_PTR_HI = 2'd1;
  localparam logic [1:0] OFF_SPARE  = 2'd2;
  localparam logic [1:0] OFF_DATA   = 2'd3;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam int         NUM_LOCKS      = 2;
  localparam int         LOCK_FIRST_BLK = 2;
endpackage

// File: rtl/nvp_pointer.sv
module nvp_pointer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_lo,
  input  logic        ld_hi,
  input  logic        clr,
  input  logic [7:0]  din,
  output logic [15:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (clr)   ptr <= '0;
    else if (ld_lo) ptr[7:0]  <= din;
    else if (ld_hi) ptr[15:8] <= din;
  end
endmodule

// File: rtl/nvp_guard.sv
module nvp_guard
  import nvp_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int EXT_BASE  = 1008,
  parameter bit EXT_FULL  = 1'b1
) (
  input  logic [15:0]          ptr,
  input  logic [NUM_LOCKS-1:0] lock,
  output logic                 wr_ok,
  output logic                 rd_blank,
  output logic                 rd_flag
);
  localparam logic [16:0] LIMIT = 17'(MEM_BYTES);

  logic                 in_range;
  logic                 flag_hit;
  logic [NUM_LOCKS-1:0] lock_hit;

  assign in_range = {1'b0, ptr} < LIMIT;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    assign lock_hit[i] = lock[i] && (ptr[15:4] == 12'(LOCK_FIRST_BLK + i));
  end

  if (EXT_FULL) begin : g_full
    assign flag_hit = (ptr == 16'(EXT_BASE));
  end else begin : g_lite
    assign flag_hit = 1'b0;
  end

  assign rd_blank = !in_range || (|lock_hit);
  assign rd_flag  = flag_hit;
  assign wr_ok    = !rd_blank && !flag_hit;
endmodule

// File: rtl/nvp_store.sv
module nvp_store #(
  parameter int MEM_BYTES = 1024,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/nvram_window_port.sv
module nvram_window_port
  import nvp_pkg::*;
#(
  parameter int         MEM_BYTES   = 1024,
  parameter int         EXT_BASE    = MEM_BYTES - 16,
  parameter bit         EXT_FULL    = 1'b1,
  parameter logic [7:0] FLAGS_VALUE = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [1:0]           req_off,
  input  logic [7:0]           req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [7:0]           rsp_data,
  input  logic [NUM_LOCKS-1:0] lock_tgl
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [15:0]          ptr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  logic                 acc, wr_acc, rd_acc;
  logic                 wr_ok, rd_blank, rd_flag;
  logic [7:0]           mem_rdata, rd_val;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;

  nvp_pointer u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (wr_acc && req_off == OFF_PTR_LO),
    .ld_hi (wr_acc && req_off == OFF_PTR_HI),
    .clr   (wr_acc && req_off == OFF_DATA),
    .din   (req_wdata),
    .ptr   (ptr_q)
  );

  nvp_guard #(
    .MEM_BYTES (MEM_BYTES),
    .EXT_BASE  (EXT_BASE),
    .EXT_FULL  (EXT_FULL)
  ) u_guard (
    .ptr      (ptr_q),
    .lock     (lock_q),
    .wr_ok    (wr_ok),
    .rd_blank (rd_blank),
    .rd_flag  (rd_flag)
  );

  nvp_store #(.MEM_BYTES(MEM_BYTES)) u_store (
    .clk   (clk),
    .we    (wr_acc && req_off == OFF_DATA && wr_ok),
    .idx   (ptr_q[AW-1:0]),
    .wdata (req_wdata),
    .rdata (mem_rdata)
  );

  always_comb begin
    if (req_off != OFF_DATA || rd_blank) rd_val = BLANK_BYTE;
    else if (rd_flag)                    rd_val = FLAGS_VALUE;
    else                                 rd_val = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= BLANK_BYTE;
      lock_q    <= '0;
    end else begin
      lock_q <= lock_q ^ lock_tgl;
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvp_checker.sv
module nvp_checker #(
  parameter int MEM_BYTES = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_off,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic [15:0] ptr
);
  localparam logic [16:0] LIMIT = 17'(MEM_BYTES);

  logic take_rd, take_wr;
  assign take_rd = req_valid && req_ready && !req_write;
  assign take_wr = req_valid && req_ready && req_write;

  AST_PTR_ZERO_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr && req_off == 2'd3 |=> ptr == 16'h0000); // R2
  AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd |=> $stable(ptr)); // R3
  AST_SIDE_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && req_off != 2'd3 |=> rsp_data == 8'hFF); // R3
  AST_OOR_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && req_off == 2'd3 && {1'b0, ptr} >= LIMIT |=> rsp_data == 8'hFF); // R8
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd |=> rsp_valid); // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
endmodule

bind nvram_window_port nvp_checker #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_off   (req_off),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ptr       (ptr_q)
);

// File: tb/nvram_window_port_bench.sv
module nvram_window_port_bench;
  localparam int         MB   = 128;
  localparam int         EXTB = 'h70;
  localparam logic [7:0] FLG  = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_off = 2'd0;
  logic [7:0] req_wdata = 8'h00;
  logic [1:0] lock_tgl = 2'b00;
  logic       req_ready, rsp_valid, req_ready_l, rsp_valid_l;
  logic [7:0] rsp_data, rsp_data_l;

  int nvec = 0, nerr = 0;
  logic [7:0] mf [MB];
  logic [7:0] ml [MB];
  logic [1:0] lk = 2'b00;

  always #5 clk = ~clk;

  nvram_window_port #(.MEM_BYTES(MB), .EXT_BASE(EXTB), .EXT_FULL(1'b1), .FLAGS_VALUE(FLG))
  u_nvram_window_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .lock_tgl(lock_tgl));

  nvram_window_port #(.MEM_BYTES(MB), .EXT_BASE(EXTB), .EXT_FULL(1'b0), .FLAGS_VALUE(FLG))
  u_nvram_window_port_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_l),
    .req_write(req_write), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_l), .rsp_ready(rsp_ready), .rsp_data(rsp_data_l), .lock_tgl(lock_tgl));

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'(a * 37 + 11 + salt) ^ 8'(a >> 5);
  endfunction

  function automatic bit locked(input int a);
    return (lk[0] && a >= 'h20 && a <= 'h2F) || (lk[1] && a >= 'h30 && a <= 'h3F);
  endfunction

  function automatic string tag_of(input int a);
    if (a >= MB) return "R8";
    if (a == EXTB) return "R9";
    if (a >= 'h20 && a <= 'h2F) return "R5";
    if (a >= 'h30 && a <= 'h3F) return "R6";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [1:0] off, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_off = off; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_addr(input int a);
    xfer(1'b1, 2'd0, 8'(a));
    xfer(1'b1, 2'd1, 8'(a >> 8));
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    set_addr(a);
    xfer(1'b1, 2'd3, d);
    if (a < MB && !locked(a)) begin
      ml[a] = d;
      if (a != EXTB) mf[a] = d;
    end
  endtask

  task automatic peek_chk(input int a, input string tag);
    logic [7:0] ef, el;
    set_addr(a);
    xfer(1'b0, 2'd3, 8'h00);
    if (a >= MB || locked(a)) begin ef = 8'hFF; el = 8'hFF; end
    else begin ef = (a == EXTB) ? FLG : mf[a]; el = ml[a]; end
    chk(tag, rsp_data, ef);
    chk(tag, rsp_data_l, el);
  endtask

  task automatic toggle(input logic [1:0] m);
    lock_tgl = m;
    @(negedge clk);
    lock_tgl = 2'b00;
    lk = lk ^ m;
  endtask

  task automatic sweep_locks(input int salt);
    for (int a = 'h1E; a <= 'h41; a++) poke(a, pat(a, salt));
    for (int a = 'h1E; a <= 'h41; a++) peek_chk(a, tag_of(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R10 reset req_ready", {7'd0, req_ready}, 8'd1);
    // R7 locks clear after reset
    poke('h22, 8'h5A);
    peek_chk('h22, "R7 reset lock clear");
    // Full sweep: write every address, then read back (R1 R8 R9)
    for (int a = 0; a < MB + 16; a++) poke(a, pat(a, 0));
    poke('h100, 8'h77);
    poke('hFFFF, 8'h66);
    for (int a = 0; a < MB + 16; a++) peek_chk(a, tag_of(a));
    peek_chk('h100, "R8 far");
    peek_chk('hFFFF, "R8 top");
    // R2 pointer cleared after a data write
    poke(5, 8'h3C);
    xfer(1'b1, 2'd3, 8'hC3);
    mf[0] = 8'hC3; ml[0] = 8'hC3;
    peek_chk(0, "R2 clear target");
    peek_chk(5, "R2 prior write");
    // R3 reads keep the pointer
    set_addr(9);
    xfer(1'b0, 2'd3, 8'h00);
    chk("R3 first read", rsp_data, mf[9]);
    xfer(1'b0, 2'd3, 8'h00);
    chk("R3 repeat read", rsp_data, mf[9]);
    // R3 side offsets read blank
    for (int o = 0; o < 3; o++) begin
      xfer(1'b0, 2'(o), 8'h00);
      chk("R3 side offset", rsp_data, 8'hFF);
    end
    // R4 offset 2 write has no effect
    set_addr(10);
    xfer(1'b1, 2'd2, 8'h00);
    xfer(1'b0, 2'd3, 8'h00);
    chk("R4 spare offset", rsp_data, mf[10]);
    peek_chk(0, "R4 memory untouched");
    // R5 R6 R7 lock sweeps
    toggle(2'b01); sweep_locks(1);
    toggle(2'b11); sweep_locks(2);
    toggle(2'b01); sweep_locks(3);
    toggle(2'b10); sweep_locks(4);
    // R10 back-pressure
    set_addr(20);
    rsp_ready = 1'b0;
    xfer(1'b0, 2'd3, 8'h00);
    chk("R10 stalled req_ready", {7'd0, req_ready}, 8'd0);
    repeat (3) @(negedge clk);
    chk("R10 held valid", {7'd0, rsp_valid}, 8'd1);
    chk("R10 held data", rsp_data, mf[20]);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", {7'd0, rsp_valid}, 8'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule